// File: doc/BRIEF.md
# Sign-Magnitude Saturating Accumulator Adder

This block adds two sign-magnitude numbers and returns their sum in the same format. It serves as the accumulate stage of a multiply-accumulate datapath. Each operand is a sign bit plus an unsigned magnitude, 16 bits by default. In the default format the magnitude holds 3 integer bits and 13 fraction bits, so one unit of the binary point is 8192. The sum leaves a single output register, so a result appears one clock after its operands are sampled. Rounding to a narrower output width is left to a later stage.

An operand pair is classified into one of three operations. When the signs agree the magnitudes are added and the shared sign is kept (ADD). When the signs differ the block forms both differences, a−b and b−a. It keeps the one that is not negative and takes the sign of the operand with the larger magnitude (SUB_AB when |a| ≥ |b|, SUB_BA otherwise). An addition whose magnitude does not fit clamps to the all-ones magnitude with the operands' sign and raises a saturation flag. A zero result is always given a positive sign.

There is no sequential control beyond the result register, so the operation enum takes the place of a state. It is decoded afresh every cycle: ADD, SUB_AB or SUB_BA.

Top module: `smsat_add`

## Requirements
- R1: While `rst_n` is low, `sum_sign`, `sum_mag` and `sat_flag` are all 0, whatever the operand inputs are.
- R2: When `a_sign` equals `b_sign` and `a_mag + b_mag` fits in the magnitude width, `sum_mag` is that sum and `sum_sign` is the common sign, except that a zero sum is given sign 0.
- R3: When the signs differ, `sum_mag` is the absolute difference of the two magnitudes. `sum_sign` is the sign of the operand with the strictly larger magnitude.
- R4: +1.0 (sign 0, magnitude 8192) added to −1.96875 (sign 1, magnitude 16128) gives sign 1 with magnitude 7936 (−0.96875). The result is the same with the operands swapped.
- R5: When the signs agree and `a_mag + b_mag` exceeds the all-ones magnitude, `sum_mag` is all ones, `sum_sign` is the common sign and `sat_flag` is 1.
- R6: A zero `sum_mag` always comes with `sum_sign` = 0. This holds for equal magnitudes of opposite sign and for two negative zeros.
- R7: The outputs change only at a rising clock edge. They show the result for the operands sampled at that edge, and a new operand pair every cycle gives a new result every cycle.
- R8: `sat_flag` is 0 whenever the signs differ, even with both magnitudes at all ones, and whenever a same-sign sum fits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the result register |
| a_sign | input | 1 | Sign of operand a (1 = negative) |
| a_mag | input | MAG_W | Magnitude of operand a |
| b_sign | input | 1 | Sign of operand b (1 = negative) |
| b_mag | input | MAG_W | Magnitude of operand b |
| sum_sign | output | 1 | Sign of the registered sum |
| sum_mag | output | MAG_W | Magnitude of the registered sum |
| sat_flag | output | 1 | High when the registered sum was clamped |

## Verification
On every cycle the assertions compare the registered result with the operands captured at the previous edge. They check the same-sign sum, the difference magnitude and sign for opposite signs, the clamp value and flag on overflow, and the absence of negative zero. The bench scenarios show the reset values while the inputs are busy, and the fixed ±1.96875 example in both operand orders. They also show the exact saturation boundary (a sum of exactly all ones against one more than that) and the pipelined behaviour when a fresh pair arrives each cycle.

// File: rtl/smsat_pkg.sv
package smsat_pkg;

    localparam int SMSAT_MAG_W = 16;

    // Operation picked from the operand signs and magnitudes
    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_SUB_AB = 2'd1,
        OP_SUB_BA = 2'd2
    } op_e;

endpackage

// File: rtl/smsat_op_decode.sv
module smsat_op_decode
    import smsat_pkg::*;
#(
    parameter int MAG_W = SMSAT_MAG_W
) (
    input  logic             a_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] b_mag,
    output op_e              op
);

    always_comb begin
        if (a_sign == b_sign) begin
            op = OP_ADD;
        end else if (a_mag >= b_mag) begin
            op = OP_SUB_AB;
        end else begin
            op = OP_SUB_BA;
        end
    end

endmodule

// File: rtl/smsat_mag_arith.sv
module smsat_mag_arith #(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W-1:0] a_mag,
    input  logic [MAG_W-1:0] b_mag,
    output logic [MAG_W:0]   sum_wide,
    output logic [MAG_W-1:0] diff_ab,
    output logic [MAG_W-1:0] diff_ba
);

    // Both differences are formed in parallel; the selector keeps the valid one
    assign sum_wide = {1'b0, a_mag} + {1'b0, b_mag};
    assign diff_ab  = a_mag - b_mag;
    assign diff_ba  = b_mag - a_mag;

endmodule

// File: rtl/smsat_result_sel.sv
module smsat_result_sel
    import smsat_pkg::*;
#(
    parameter int MAG_W = SMSAT_MAG_W
) (
    input  op_e              op,
    input  logic             a_sign,
    input  logic             b_sign,
    input  logic [MAG_W:0]   sum_wide,
    input  logic [MAG_W-1:0] diff_ab,
    input  logic [MAG_W-1:0] diff_ba,
    output logic             r_sign,
    output logic [MAG_W-1:0] r_mag,
    output logic             r_sat
);

    logic raw_sign;

    always_comb begin
        raw_sign = 1'b0;
        r_mag    = '0;
        r_sat    = 1'b0;
        unique case (op)
            OP_ADD: begin
                raw_sign = a_sign;
                if (sum_wide[MAG_W]) begin
                    r_mag = '1;
                    r_sat = 1'b1;
                end else begin
                    r_mag = sum_wide[MAG_W-1:0];
                end
            end
            OP_SUB_AB: begin
                raw_sign = a_sign;
                r_mag    = diff_ab;
            end
            OP_SUB_BA: begin
                raw_sign = b_sign;
                r_mag    = diff_ba;
            end
            default: begin
                raw_sign = 1'b0;
                r_mag    = '0;
            end
        endcase
        // Zero is always reported as positive
        r_sign = raw_sign & (|r_mag);
    end

endmodule

// File: rtl/smsat_add.sv
module smsat_add
    import smsat_pkg::*;
#(
    parameter int MAG_W = SMSAT_MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] b_mag,
    output logic             sum_sign,
    output logic [MAG_W-1:0] sum_mag,
    output logic             sat_flag
);

    op_e              op;
    logic [MAG_W:0]   sum_wide;
    logic [MAG_W-1:0] diff_ab;
    logic [MAG_W-1:0] diff_ba;
    logic             r_sign;
    logic [MAG_W-1:0] r_mag;
    logic             r_sat;

    smsat_op_decode #(.MAG_W(MAG_W)) u_decode (
        .a_sign (a_sign),
        .a_mag  (a_mag),
        .b_sign (b_sign),
        .b_mag  (b_mag),
        .op     (op)
    );

    smsat_mag_arith #(.MAG_W(MAG_W)) u_arith (
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .sum_wide (sum_wide),
        .diff_ab  (diff_ab),
        .diff_ba  (diff_ba)
    );

    smsat_result_sel #(.MAG_W(MAG_W)) u_select (
        .op       (op),
        .a_sign   (a_sign),
        .b_sign   (b_sign),
        .sum_wide (sum_wide),
        .diff_ab  (diff_ab),
        .diff_ba  (diff_ba),
        .r_sign   (r_sign),
        .r_mag    (r_mag),
        .r_sat    (r_sat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_sign <= 1'b0;
            sum_mag  <= '0;
            sat_flag <= 1'b0;
        end else begin
            sum_sign <= r_sign;
            sum_mag  <= r_mag;
            sat_flag <= r_sat;
        end
    end

endmodule

// File: rtl/smsat_add_chk.sv
module smsat_add_chk #(
    parameter int MAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_sign,
    input logic [MAG_W-1:0] a_mag,
    input logic             b_sign,
    input logic [MAG_W-1:0] b_mag,
    input logic             sum_sign,
    input logic [MAG_W-1:0] sum_mag,
    input logic             sat_flag
);

    localparam logic [MAG_W:0] MAX_V = {1'b0, {MAG_W{1'b1}}};

    logic             p_valid;
    logic             p_as;
    logic             p_bs;
    logic [MAG_W-1:0] p_am;
    logic [MAG_W-1:0] p_bm;
    logic [MAG_W:0]   p_sum;
    logic [MAG_W-1:0] p_absdiff;
    logic             p_big_sign;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_as    <= 1'b0;
            p_bs    <= 1'b0;
            p_am    <= '0;
            p_bm    <= '0;
        end else begin
            p_valid <= 1'b1;
            p_as    <= a_sign;
            p_bs    <= b_sign;
            p_am    <= a_mag;
            p_bm    <= b_mag;
        end
    end

    assign p_sum      = {1'b0, p_am} + {1'b0, p_bm};
    assign p_absdiff  = (p_am > p_bm) ? (p_am - p_bm) : (p_bm - p_am);
    assign p_big_sign = (p_am > p_bm) ? p_as : p_bs;

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_as == p_bs && p_sum <= MAX_V) |->
        ({1'b0, sum_mag} == p_sum && sum_sign == (p_as && p_sum != '0) && !sat_flag));

    // R3
    sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_as != p_bs) |-> (sum_mag == p_absdiff));

    // R3
    sub_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_as != p_bs && p_am != p_bm) |-> (sum_sign == p_big_sign));

    // R5
    sat_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_as == p_bs && p_sum > MAX_V) |->
        (sat_flag && sum_mag == '1 && sum_sign == p_as));

    // R6
    pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_mag == '0) |-> !sum_sign);

    // R8
    sub_nosat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_as != p_bs) |-> !sat_flag);

endmodule

bind smsat_add smsat_add_chk #(.MAG_W(MAG_W)) u_smsat_add_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_sign   (a_sign),
    .a_mag    (a_mag),
    .b_sign   (b_sign),
    .b_mag    (b_mag),
    .sum_sign (sum_sign),
    .sum_mag  (sum_mag),
    .sat_flag (sat_flag)
);

// File: tb/test_smsat_add.sv
module test_smsat_add;

    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_sign = 1'b0;
    logic [MW-1:0] a_mag = '0;
    logic          b_sign = 1'b0;
    logic [MW-1:0] b_mag = '0;
    logic          sum_sign;
    logic [MW-1:0] sum_mag;
    logic          sat_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    smsat_add #(.MAG_W(MW)) i_smsat_add (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_sign   (a_sign),
        .a_mag    (a_mag),
        .b_sign   (b_sign),
        .b_mag    (b_mag),
        .sum_sign (sum_sign),
        .sum_mag  (sum_mag),
        .sat_flag (sat_flag)
    );

    task automatic check_out(input string req, input logic es, input logic [MW-1:0] em,
                             input logic esat);
        n_checks++;
        if (sum_sign !== es || sum_mag !== em || sat_flag !== esat) begin
            n_fail++;
            $display("FAIL %s: got sign=%0b mag=%0d sat=%0b, expected sign=%0b mag=%0d sat=%0b",
                     req, sum_sign, sum_mag, sat_flag, es, em, esat);
        end
    endtask

    // Expected result from signed integer arithmetic
    task automatic expect_of(input logic as, input logic [MW-1:0] am, input logic bs,
                             input logic [MW-1:0] bm, output logic es,
                             output logic [MW-1:0] em, output logic esat);
        int va;
        int vb;
        int t;
        int mag;
        int maxv;
        maxv = (1 << MW) - 1;
        va   = as ? -int'(am) : int'(am);
        vb   = bs ? -int'(bm) : int'(bm);
        t    = va + vb;
        mag  = (t < 0) ? -t : t;
        esat = (mag > maxv);
        em   = esat ? MW'(maxv) : MW'(mag);
        es   = (t < 0);
    endtask

    task automatic drive(input logic as, input logic [MW-1:0] am, input logic bs,
                         input logic [MW-1:0] bm);
        a_sign = as;
        a_mag  = am;
        b_sign = bs;
        b_mag  = bm;
    endtask

    // Apply at a falling edge, sample at the next falling edge
    task automatic run_one(input string req, input logic as, input logic [MW-1:0] am,
                           input logic bs, input logic [MW-1:0] bm);
        logic es;
        logic [MW-1:0] em;
        logic esat;
        drive(as, am, bs, bm);
        expect_of(as, am, bs, bm, es, em, esat);
        @(negedge clk);
        check_out(req, es, em, esat);
    endtask

    task automatic t_reset;
        drive(1'b1, 16'h1234, 1'b1, 16'hFFFF);
        @(negedge clk);
        check_out("R1 reset with busy inputs", 1'b0, '0, 1'b0);
        @(negedge clk);
        check_out("R1 reset held", 1'b0, '0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_same_sign;
        run_one("R2 positive add", 1'b0, 16'd8192, 1'b0, 16'd4096);
        check_out("R2 positive add value", 1'b0, 16'd12288, 1'b0);
        run_one("R2 negative add", 1'b1, 16'd300, 1'b1, 16'd45);
        check_out("R2 negative add value", 1'b1, 16'd345, 1'b0);
    endtask

    task automatic t_diff_sign;
        run_one("R3 a larger negative", 1'b1, 16'd5000, 1'b0, 16'd1200);
        check_out("R3 a larger value", 1'b1, 16'd3800, 1'b0);
        run_one("R3 b larger negative", 1'b0, 16'd100, 1'b1, 16'd900);
        check_out("R3 b larger value", 1'b1, 16'd800, 1'b0);
        run_one("R3 b larger positive", 1'b1, 16'd7, 1'b0, 16'd60000);
    endtask

    task automatic t_example;
        run_one("R4 +1.0 + -1.96875", 1'b0, 16'd8192, 1'b1, 16'd16128);
        check_out("R4 result -0.96875", 1'b1, 16'd7936, 1'b0);
        run_one("R4 swapped operands", 1'b1, 16'd16128, 1'b0, 16'd8192);
        check_out("R4 swapped result", 1'b1, 16'd7936, 1'b0);
    endtask

    task automatic t_overflow;
        run_one("R5 positive overflow", 1'b0, 16'hF000, 1'b0, 16'h2000);
        check_out("R5 positive clamp", 1'b0, 16'hFFFF, 1'b1);
        run_one("R5 negative overflow", 1'b1, 16'hFFFF, 1'b1, 16'h0001);
        check_out("R5 negative clamp", 1'b1, 16'hFFFF, 1'b1);
        run_one("R8 sum exactly all ones", 1'b1, 16'hFF00, 1'b1, 16'h00FF);
        check_out("R8 boundary no clamp", 1'b1, 16'hFFFF, 1'b0);
    endtask

    task automatic t_zero;
        run_one("R6 equal opposite", 1'b1, 16'd4321, 1'b0, 16'd4321);
        check_out("R6 equal opposite value", 1'b0, '0, 1'b0);
        run_one("R6 equal opposite swapped", 1'b0, 16'd77, 1'b1, 16'd77);
        check_out("R6 swapped value", 1'b0, '0, 1'b0);
        run_one("R6 two negative zeros", 1'b1, '0, 1'b1, '0);
        check_out("R6 negative zeros value", 1'b0, '0, 1'b0);
    endtask

    task automatic t_no_sat_diff;
        run_one("R8 opposite max magnitudes", 1'b0, 16'hFFFF, 1'b1, 16'hFFFE);
        check_out("R8 opposite max value", 1'b0, 16'h0001, 1'b0);
    endtask

    task automatic t_pipeline;
        logic es;
        logic [MW-1:0] em;
        logic esat;
        // Back-to-back pairs, one per cycle
        for (int i = 0; i < 40; i++) begin
            logic as;
            logic bs;
            logic [MW-1:0] am;
            logic [MW-1:0] bm;
            as = i[0];
            bs = i[1] ^ i[2];
            am = MW'((i * 7919 + 13) * 37);
            bm = MW'((i * 4271 + 5) * 53);
            drive(as, am, bs, bm);
            expect_of(as, am, bs, bm, es, em, esat);
            #2;
            n_checks++;
            if (sum_mag === em && sum_sign === es && i > 0 && em !== '0) begin
                // outputs must not follow inputs before the clock edge
                n_fail++;
                $display("FAIL R7 output changed before edge: got mag=%0d expected previous", sum_mag);
            end
            @(negedge clk);
            check_out("R7 back-to-back", es, em, esat);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_same_sign();
        t_diff_sign();
        t_example();
        t_overflow();
        t_zero();
        t_no_sat_diff();
        t_pipeline();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule